// File: doc/BRIEF.md
# MDIO Management Master

This block is the master end of a two-wire serial management bus that reaches the control registers of an Ethernet PHY. A host asks for a single register access by pulsing `start` together with a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The controller then builds the whole management frame on its own. It produces the MDC clock from the system clock and drives, releases and samples the data line through a separate output, output-enable and input. Pad tristate cells sit outside the block.

Every frame opens with a long run of ones that the PHY uses to lock on. The start and opcode bits follow, then both addresses. A write continues with a fixed turnaround pattern and the data word. A read hands the line over to the PHY. Before it collects any data it checks that the PHY actually pulls the line low in the first turnaround slot. If nothing answers, the controller clocks the bus for a recovery stretch and returns all-ones data with an error flag. When the access finishes, `done` pulses for one cycle and `rdata` and `err` hold their result until the next access completes.

Top module: `mdio_master`

## Requirements
- R1: Each access begins with 32 MDC cycles during which `mdio_oe` is 1 and `mdio_o` is 1. These are MDC cycles 0 to 31, counted by rising edge from 0 after `start`.
- R2: MDC cycles 32 and 33 carry 0 then 1. Cycles 34 and 35 carry the opcode: 1,0 for a read (`rd_nwr`=1) and 0,1 for a write (`rd_nwr`=0). `mdio_oe` is 1 in all four.
- R3: MDC cycles 36 to 40 carry `phy_addr` and cycles 41 to 45 carry `reg_addr`, both most significant bit first, with `mdio_oe` at 1.
- R4: `mdio_o` and `mdio_oe` change only while MDC is low, and they hold their values across every MDC high phase. Each MDC high phase lasts exactly `HALF_CLKS` system clocks.
- R5: On a read, `mdio_oe` is 0 from MDC cycle 46 until the end. The value of `mdio_i` late in the high phase of cycle 46 is the turnaround bit. When that bit is 0, data bits 15 down to 0 are taken late in the high phases of cycles 47 to 62. Two more MDC cycles follow, so the access uses 65 MDC cycles in all. It finishes with `rdata` equal to the captured word and `err` equal to 0.
- R6: On a read where the turnaround bit is 1, the controller runs 32 further MDC cycles, for 79 in all. It finishes with `rdata` = 0xFFFF and `err` = 1.
- R7: On a write, MDC cycles 46 and 47 carry 1 then 0, and cycles 48 to 63 carry `wdata` most significant bit first, all with `mdio_oe` at 1. Cycle 64 has `mdio_oe` at 0. The access uses 65 MDC cycles and finishes with `err` = 0.
- R8: A `start` pulse while `busy` is 1 is ignored. The running frame, the MDC count and the number of `done` pulses do not change.
- R9: After reset, and whenever the controller is idle, `mdc`, `mdio_oe`, `busy` and `done` are all 0. A reset in the middle of an access stops it at once and produces no `done`.
- R10: `busy` is 1 from the cycle after an accepted `start` until the access ends. `done` is a one-cycle pulse that rises in the cycle where `busy` falls, and `rdata` and `err` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access (taken only while idle) |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data word for writes |
| rdata | output | 16 | Result of the last read (0xFFFF on no response) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | Last read saw no PHY response |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
A PHY model decodes every frame by counting MDC rising edges and answers reads with a chosen turnaround bit and data word. A design that released the line one slot early or late would show a wrong output-enable pattern or a data word shifted by one bit. Reads with a missing PHY check that the 32 recovery clocks run, that the data is forced to all ones and that the error clears again on the next good read. A valid 0xFFFF read catches a design that derives the error from the data. A stray start in the middle of a frame, and a reset in the middle of a frame, catch a controller that reloads its shifter or still emits a done pulse.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_TAR,
    ST_RDAT,
    ST_RECOV,
    ST_RELS
  } mdio_st_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic fall_tick
);
  localparam int CW = $clog2(HALF_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == CW'(HALF_CLKS - 1)) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // last system clock of an MDC high phase: the slot ends here
  assign fall_tick = mdc && (cnt == CW'(HALF_CLKS - 1));
endmodule

// File: rtl/mdio_txshift.sv
module mdio_txshift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_out = sr[W-1];
endmodule

// File: rtl/mdio_rxshift.sv
module mdio_rxshift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (en)    word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CLKS = 4,
  parameter int PRE_LEN   = 32,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int RECOV_LEN = 32,
  parameter int TRAIL_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  // full write frame: preamble, start, opcode, two addresses, turnaround, data
  localparam int FRAME_W = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  // bits a read drives before handing the line over
  localparam int HDR_W   = FRAME_W - 2 - DATA_W;
  localparam int RD_TAIL = DATA_W + TRAIL_LEN;
  localparam int MAX_A   = (FRAME_W > RECOV_LEN) ? FRAME_W : RECOV_LEN;
  localparam int MAX_C   = (MAX_A > RD_TAIL) ? MAX_A : RD_TAIL;
  localparam int CNT_W   = $clog2(MAX_C + 1);

  mdio_st_t           st;
  logic [CNT_W-1:0]   cnt;
  logic               is_rd;
  logic               fall_tick;
  logic               mdi_m, mdi_s;
  logic               tx_load, tx_shift, rx_en;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  rx_word;

  // two-flop capture of the pad input; the bus idles high
  always_ff @(posedge clk) begin
    if (rst) begin
      mdi_m <= 1'b1;
      mdi_s <= 1'b1;
    end else begin
      mdi_m <= mdio_i;
      mdi_s <= mdi_m;
    end
  end

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, (rd_nwr ? 2'b10 : 2'b01),
                  phy_addr, reg_addr, 2'b10, wdata};

  assign tx_load  = (st == ST_IDLE) && start;
  assign tx_shift = (st == ST_HDR) && fall_tick && (cnt != '0);
  assign rx_en    = (st == ST_RDAT) && fall_tick && (cnt >= CNT_W'(TRAIL_LEN));

  mdio_clkgen #(.HALF_CLKS(HALF_CLKS)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .mdc       (mdc),
    .fall_tick (fall_tick)
  );

  mdio_txshift #(.W(FRAME_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load    (tx_load),
    .shift   (tx_shift),
    .din     (frame),
    .bit_out (mdio_o)
  );

  mdio_rxshift #(.W(DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clr    (tx_load),
    .en     (rx_en),
    .bit_in (mdi_s),
    .word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      is_rd   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            is_rd   <= rd_nwr;
            busy    <= 1'b1;
            mdio_oe <= 1'b1;
            cnt     <= rd_nwr ? CNT_W'(HDR_W - 1) : CNT_W'(FRAME_W - 1);
            st      <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (fall_tick) begin
            if (cnt == '0) begin
              mdio_oe <= 1'b0;
              st      <= is_rd ? ST_TAR : ST_RELS;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_TAR: begin
          if (fall_tick) begin
            if (!mdi_s) begin
              cnt <= CNT_W'(RD_TAIL - 1);
              st  <= ST_RDAT;
            end else begin
              cnt <= CNT_W'(RECOV_LEN - 1);
              st  <= ST_RECOV;
            end
          end
        end
        ST_RDAT: begin
          if (fall_tick) begin
            if (cnt == '0) begin
              rdata <= rx_word;
              err   <= 1'b0;
              busy  <= 1'b0;
              done  <= 1'b1;
              st    <= ST_IDLE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_RECOV: begin
          if (fall_tick) begin
            if (cnt == '0) begin
              rdata <= '1;
              err   <= 1'b1;
              busy  <= 1'b0;
              done  <= 1'b1;
              st    <= ST_IDLE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_RELS: begin
          if (fall_tick) begin
            err  <= 1'b0;
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] rdata,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  // R4: data line and its enable hold while MDC is high
  p_mdio_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R4: an MDC high phase lasts longer than one system clock
  p_half_min_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |=> mdc);

  // R1: an accepted start drives the line high at once
  p_start_drive_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && mdio_oe && mdio_o));

  // R9: idle means clock low and line released
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc));

  // R10: done lasts a single cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: done marks the cycle busy falls
  p_done_end_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R6: a failed read reports all ones
  p_err_ones_r6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rdata == '1));
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .rdata   (rdata),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_nwr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy, done, err, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_master #(.HALF_CLKS(HALF)) dut (
    .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .done(done), .err(err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic        rd;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [15:0] wd;
    logic        ta;
    logic [15:0] rv;
    logic        inject;
  } item_t;

  item_t q[$];

  int n_chk = 0;
  int n_bad = 0;
  int n_done = 0;
  int n_exp = 0;
  int hold_viol = 0;
  int half_viol = 0;
  bit finished = 0;

  // PHY model state
  logic        cur_rd = 1'b0;
  logic        cur_ta = 1'b0;
  logic [15:0] cur_rv = '0;
  int          rises = 0;
  logic        cap_o  [0:127];
  logic        cap_oe [0:127];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // PHY model and line observer, all at the falling system clock edge
  always @(negedge clk) begin
    logic pm, pb, po, poe;
    int   hi;
    if (rst) begin
      pm = 0; pb = 0; hi = 0;
    end else begin
      if (busy && !pb) rises = 0;
      if (mdc && pm && (mdio_o !== po || mdio_oe !== poe)) hold_viol++;
      if (mdc) hi++;
      else begin
        if (hi != 0 && hi != HALF) half_viol++;
        hi = 0;
      end
      if (mdc && !pm) begin
        if (rises < 128) begin
          cap_o[rises]  = mdio_o;
          cap_oe[rises] = mdio_oe;
        end
        if (cur_rd && rises == 46)                   mdio_i <= cur_ta;
        else if (cur_rd && rises >= 47 && rises <= 62) mdio_i <= cur_rv[62 - rises];
        else                                          mdio_i <= 1'b1;
        rises++;
      end
      pm = mdc; pb = busy; po = mdio_o; poe = mdio_oe;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      item_t it;
      logic [63:0] ef;
      int bad_pre, bad_so, bad_adr, bad_tail;
      n_done++;
      chk(busy == 1'b0, "R10 busy low with done", busy, 0);
      if (q.size() == 0) begin
        chk(0, "R8 unexpected done", 1, 0);
      end else begin
        it = q.pop_front();
        ef = {32'hFFFF_FFFF, 2'b01, (it.rd ? 2'b10 : 2'b01), it.pa, it.ra, 2'b10, it.wd};
        bad_pre = 0; bad_so = 0; bad_adr = 0; bad_tail = 0;
        for (int k = 0; k < 32; k++) if (cap_o[k] !== 1'b1 || cap_oe[k] !== 1'b1) bad_pre++;
        for (int k = 32; k < 36; k++) if (cap_o[k] !== ef[63-k] || cap_oe[k] !== 1'b1) bad_so++;
        for (int k = 36; k < 46; k++) if (cap_o[k] !== ef[63-k] || cap_oe[k] !== 1'b1) bad_adr++;
        chk(bad_pre == 0, "R1 preamble bits", bad_pre, 0);
        chk(bad_so == 0, "R2 start/opcode bits", bad_so, 0);
        chk(bad_adr == 0, it.inject ? "R8 R3 address after stray start" : "R3 address bits", bad_adr, 0);
        if (it.rd) begin
          for (int k = 46; k < rises && k < 128; k++) if (cap_oe[k] !== 1'b0) bad_tail++;
          chk(bad_tail == 0, "R5 line released after header", bad_tail, 0);
          if (it.ta) begin
            chk(rises == 79, "R6 mdc count", rises, 79);
            chk(rdata == 16'hFFFF, "R6 rdata", rdata, 16'hFFFF);
            chk(err == 1'b1, "R6 err", err, 1);
          end else begin
            chk(rises == 65, "R5 mdc count", rises, 65);
            chk(rdata == it.rv, "R5 rdata", rdata, it.rv);
            chk(err == 1'b0, "R5 err", err, 0);
          end
        end else begin
          for (int k = 46; k < 64; k++) if (cap_o[k] !== ef[63-k] || cap_oe[k] !== 1'b1) bad_tail++;
          chk(bad_tail == 0, "R7 turnaround and data bits", bad_tail, 0);
          chk(cap_oe[64] === 1'b0, "R7 released final cycle", cap_oe[64], 0);
          chk(rises == 65, it.inject ? "R8 mdc count" : "R7 mdc count", rises, 65);
          chk(err == 1'b0, "R7 err", err, 0);
        end
      end
    end
  end

  task automatic txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input logic ta, input logic [15:0] rv,
                     input bit inject);
    item_t it;
    it.rd = rd; it.pa = pa; it.ra = ra; it.wd = wd; it.ta = ta; it.rv = rv; it.inject = inject;
    q.push_back(it);
    n_exp++;
    @(negedge clk);
    cur_rd = rd; cur_ta = ta; cur_rv = rv;
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (150) @(negedge clk);
      rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(mdc == 0, "R9 mdc after reset", mdc, 0);
    chk(mdio_oe == 0, "R9 oe after reset", mdio_oe, 0);
    chk(busy == 0, "R9 busy after reset", busy, 0);
    chk(done == 0, "R9 done after reset", done, 0);

    txn(1'b0, 5'h01, 5'h00, 16'h1234, 1'b0, 16'h0000, 0);
    txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b0, 16'hA5C3, 0);
    txn(1'b1, 5'h0A, 5'h02, 16'h0000, 1'b1, 16'h0000, 0);
    txn(1'b1, 5'h03, 5'h11, 16'h0000, 1'b0, 16'h0000, 0);
    txn(1'b0, 5'h10, 5'h01, 16'hFFFF, 1'b0, 16'h0000, 1);
    txn(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b0, 16'hFFFF, 0);
    txn(1'b0, 5'h00, 5'h15, 16'h0000, 1'b0, 16'h0000, 0);
    txn(1'b1, 5'h07, 5'h1C, 16'h0000, 1'b0, 16'h8001, 1);

    // R9 reset in the middle of an access
    cur_rd = 1'b1; cur_ta = 1'b0; cur_rv = 16'h5555;
    rd_nwr = 1'b1; phy_addr = 5'h05; reg_addr = 5'h06; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0 && busy == 0, "R9 quiet after mid-frame reset",
        {mdc, mdio_oe, busy}, 0);
    repeat (700) @(negedge clk);
    chk(busy == 0, "R9 stays idle after mid-frame reset", busy, 0);

    txn(1'b1, 5'h0C, 5'h0D, 16'h0000, 1'b1, 16'h0000, 0);

    chk(n_done == n_exp, "R8 done pulse count", n_done, n_exp);
    chk(hold_viol == 0, "R4 line changed during mdc high", hold_viol, 0);
    chk(half_viol == 0, "R4 mdc high phase length", half_viol, 0);
    finished = 1;
    summary();
  end
endmodule